// File: doc/BRIEF.md
# Correctable-Error Location Bitmap

This block keeps a one-bit-per-location record of corrected memory errors for a memory of two 128K-word halves. Every read event that arrives with a nonzero error-correction syndrome sets one flag in the live log of the half it belongs to. The flag's index joins the syndrome to the upper bits of the word address, so each flag stands for a particular combination of failing bit position and address region. The flag stays set no matter how often the same error repeats. Logging accepts one event every clock and never stalls the memory cycle.

A host interrogates one half at a time. A snapshot pulse copies the selected live log into a scan buffer and clears that live log in the same clock. The scanner then walks the buffer from index 0 upward and presents each set flag's index in turn. The host steps to the next flag with a one-cycle request. When no flag remains, the scanner reports completion.

The scanner is a state machine with four states. SC_IDLE is the state after reset. SC_SEEK examines one chunk of the buffer per cycle. SC_REPORT holds a found index. SC_DONE is entered when no flags remain. The transitions are:
- snapshot: any state goes to SC_SEEK.
- hit: SC_SEEK goes to SC_REPORT.
- advance: SC_SEEK stays in SC_SEEK on the next chunk.
- exhausted: SC_SEEK on the last chunk with no flag goes to SC_DONE.
- next: SC_REPORT goes to SC_SEEK.

Top module: `elog_bitmap_top`

## Requirements
- R1: After reset `flag_valid` and `scan_done` are 0 and both live logs are empty, so a first snapshot of either half scans straight to `scan_done`=1 with no flag reported.
- R2: A cycle with `ev_valid`=1 and `ev_syndrome`≠0 sets the flag at index {`ev_syndrome`, `ev_addr[16:12]`}: syndrome in index bits 9..5, address bits 16..12 in index bits 4..0. `ev_addr[17]`=0 selects the lower log and 1 selects the upper log.
- R3: An event with `ev_valid`=0, or with `ev_syndrome`=0, sets no flag. A later scan of that half shows no index for it.
- R4: Logging an index that is already set leaves it set, and the index is reported only once in the scan.
- R5: A `host_snap` pulse with `host_sel` (0 lower, 1 upper) copies that log into the scan buffer and clears it in the same clock. The other log is untouched.
- R6: An event that targets the selected log in the same cycle as its snapshot is absent from that snapshot. It stays in the live log and appears in the next snapshot.
- R7: During a scan, `flag_valid`=1 presents the lowest set index not yet stepped past on `flag_index`. The index is held stable until `host_next`. Each `host_next` moves to the next higher set index.
- R8: When no set flag remains, `scan_done`=1 with `flag_valid`=0. This holds until the next snapshot, and `host_next` has no effect in that state.
- R9: A `host_snap` during a scan discards the scan in progress and restarts from index 0 on the new snapshot.
- R10: Events are accepted on consecutive cycles, including while a scan is running, and every one is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Read event present this cycle |
| ev_syndrome | input | 5 | Error-correction syndrome of the read, 0 when clean |
| ev_addr | input | 18 | Word address of the read; bit 17 picks the half |
| host_snap | input | 1 | Pulse: capture and clear the selected log |
| host_sel | input | 1 | Half to capture, 0 lower, 1 upper |
| host_next | input | 1 | Pulse: step past the presented flag |
| flag_valid | output | 1 | A set flag is presented |
| flag_index | output | 10 | Index of the presented flag |
| scan_done | output | 1 | No further set flags in the scan buffer |

## Verification
The hardest situations to reach are the ones where a host action and an event land on the same clock edge. One is an event for the selected half arriving in the very cycle of its snapshot. The other is a fresh snapshot taken while a flag is still being presented. The stimulus drives the snapshot pulse and the event together in one cycle, and it issues a second snapshot while the scanner sits on its first flag. A parallel thread pours consecutive events into one half while the other half is being scanned. Chosen indices sit on both sides of the scanner's chunk boundaries and at the two extreme indices.

// File: rtl/elog_pkg.sv
package elog_pkg;
    typedef enum logic [1:0] {
        SC_IDLE   = 2'd0,
        SC_SEEK   = 2'd1,
        SC_REPORT = 2'd2,
        SC_DONE   = 2'd3
    } scan_state_e;
endpackage

// File: rtl/elog_addr_map.sv
module elog_addr_map #(
    parameter int SYN_W  = 5,
    parameter int HI_W   = 5,
    parameter int HALF_W = 17,
    parameter int BANK_W = 1,
    localparam int ADDR_W = HALF_W + BANK_W,
    localparam int IDX_W  = SYN_W + HI_W,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic              ev_valid_i,
    input  logic [SYN_W-1:0]  ev_syndrome_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    output logic [NBANK-1:0]  bank_hit_o,
    output logic [IDX_W-1:0]  set_idx_o
);
    logic              corrected;
    logic [BANK_W-1:0] bank_num;

    always_comb begin
        corrected = ev_valid_i && (ev_syndrome_i != '0);
        bank_num  = ev_addr_i[ADDR_W-1 -: BANK_W];
        set_idx_o = {ev_syndrome_i, ev_addr_i[HALF_W-1 -: HI_W]};
        for (int b = 0; b < NBANK; b++) begin
            bank_hit_o[b] = corrected && (bank_num == BANK_W'(b));
        end
    end
endmodule

// File: rtl/elog_bank.sv
module elog_bank #(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  logic [IDX_W-1:0] set_idx_i,
    input  logic             clr_en_i,
    output logic [DEPTH-1:0] live_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_o <= '0;
        end else begin
            if (clr_en_i) live_o <= '0;
            if (set_en_i) live_o[set_idx_i] <= 1'b1;
        end
    end

    // R2 R6
    logged_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> live_o[$past(set_idx_i)]);
endmodule

// File: rtl/elog_scanner.sv
module elog_scanner
    import elog_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int CHUNK_W = 16,
    localparam int DEPTH   = 1 << IDX_W,
    localparam int OFF_W   = $clog2(CHUNK_W),
    localparam int CI_W    = IDX_W - OFF_W,
    localparam int NCHUNK  = DEPTH / CHUNK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [DEPTH-1:0] snap_data_i,
    input  logic             next_i,
    output logic             flag_valid_o,
    output logic [IDX_W-1:0] flag_index_o,
    output logic             scan_done_o
);
    localparam logic [CI_W-1:0] LAST_CHUNK = CI_W'(NCHUNK - 1);

    scan_state_e      state_q, state_d;
    logic [DEPTH-1:0] snap_buf;
    logic [CI_W-1:0]  chunk_q;
    logic [IDX_W-1:0] idx_q;
    logic [CHUNK_W-1:0] chunk_bits;
    logic [OFF_W-1:0] low_off;
    logic             chunk_hit;

    always_comb begin
        chunk_bits = snap_buf[{chunk_q, {OFF_W{1'b0}}} +: CHUNK_W];
        chunk_hit  = |chunk_bits;
        low_off    = '0;
        for (int i = CHUNK_W - 1; i >= 0; i--) begin
            if (chunk_bits[i]) low_off = OFF_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        if (snap_i) begin
            state_d = SC_SEEK;
        end else begin
            unique case (state_q)
                SC_IDLE:   state_d = SC_IDLE;
                SC_SEEK: begin
                    if (chunk_hit)                  state_d = SC_REPORT;
                    else if (chunk_q == LAST_CHUNK) state_d = SC_DONE;
                    else                            state_d = SC_SEEK;
                end
                SC_REPORT: state_d = next_i ? SC_SEEK : SC_REPORT;
                SC_DONE:   state_d = SC_DONE;
                default:   state_d = SC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_buf <= '0;
            chunk_q  <= '0;
            idx_q    <= '0;
        end else if (snap_i) begin
            snap_buf <= snap_data_i;
            chunk_q  <= '0;
        end else begin
            if (state_q == SC_SEEK) begin
                if (chunk_hit) idx_q <= {chunk_q, low_off};
                else if (chunk_q != LAST_CHUNK) chunk_q <= chunk_q + 1'b1;
            end
            if (state_q == SC_REPORT && next_i) snap_buf[idx_q] <= 1'b0;
        end
    end

    always_comb begin
        flag_valid_o = (state_q == SC_REPORT);
        scan_done_o  = (state_q == SC_DONE);
        flag_index_o = idx_q;
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid_o && !next_i && !snap_i |=> flag_valid_o && $stable(flag_index_o));
    // R7
    flag_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid_o |-> snap_buf[flag_index_o]);
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o && !snap_i |=> scan_done_o && !flag_valid_o);
    // R8
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_valid_o, scan_done_o}));
endmodule

// File: rtl/elog_bitmap_top.sv
module elog_bitmap_top #(
    parameter int SYN_W   = 5,
    parameter int HI_W    = 5,
    parameter int HALF_W  = 17,
    parameter int BANK_W  = 1,
    parameter int CHUNK_W = 16,
    localparam int ADDR_W = HALF_W + BANK_W,
    localparam int IDX_W  = SYN_W + HI_W,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [SYN_W-1:0]  ev_syndrome,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              host_snap,
    input  logic [BANK_W-1:0] host_sel,
    input  logic              host_next,
    output logic              flag_valid,
    output logic [IDX_W-1:0]  flag_index,
    output logic              scan_done
);
    logic [NBANK-1:0] bank_hit;
    logic [IDX_W-1:0] set_idx;
    logic [DEPTH-1:0] live_all [NBANK];
    logic [DEPTH-1:0] snap_data;

    elog_addr_map #(
        .SYN_W(SYN_W), .HI_W(HI_W), .HALF_W(HALF_W), .BANK_W(BANK_W)
    ) map_i (
        .ev_valid_i(ev_valid), .ev_syndrome_i(ev_syndrome), .ev_addr_i(ev_addr),
        .bank_hit_o(bank_hit), .set_idx_o(set_idx)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic clr_this;
        assign clr_this = host_snap && (host_sel == BANK_W'(b));
        elog_bank #(.IDX_W(IDX_W)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .set_en_i(bank_hit[b]), .set_idx_i(set_idx),
            .clr_en_i(clr_this), .live_o(live_all[b])
        );

        // R3
        clean_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_valid || ev_syndrome == '0) && !host_snap |=> $stable(live_all[b]));
    end

    assign snap_data = live_all[host_sel];

    elog_scanner #(.IDX_W(IDX_W), .CHUNK_W(CHUNK_W)) scan_i (
        .clk(clk), .rst_n(rst_n),
        .snap_i(host_snap), .snap_data_i(snap_data), .next_i(host_next),
        .flag_valid_o(flag_valid), .flag_index_o(flag_index), .scan_done_o(scan_done)
    );
endmodule

// File: tb/elog_bitmap_top_tb_top.sv
`timescale 1ns/1ps
module elog_bitmap_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic [4:0] ev_syndrome = '0;
    logic [17:0] ev_addr = '0;
    logic host_snap = 1'b0;
    logic host_sel = 1'b0;
    logic host_next = 1'b0;
    logic flag_valid;
    logic [9:0] flag_index;
    logic scan_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit model [2][1024];
    int exp_q [$];

    always #2.5 clk = ~clk;

    elog_bitmap_top dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_syndrome(ev_syndrome),
        .ev_addr(ev_addr), .host_snap(host_snap), .host_sel(host_sel),
        .host_next(host_next), .flag_valid(flag_valid), .flag_index(flag_index),
        .scan_done(scan_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [4:0] syn, input logic [17:0] a);
        return int'(syn) * 32 + int'(a[16:12]);
    endfunction

    task automatic model_log(input logic [4:0] syn, input logic [17:0] a);
        if (syn != 0) model[a[17]][idx_of(syn, a)] = 1'b1;
    endtask

    task automatic push_snapshot(input bit sel);
        exp_q.delete();
        for (int i = 0; i < 1024; i++) begin
            if (model[sel][i]) exp_q.push_back(i);
            model[sel][i] = 1'b0;
        end
    endtask

    task automatic send_ev(input bit v, input logic [4:0] syn, input logic [17:0] a);
        @(negedge clk);
        ev_valid = v; ev_syndrome = syn; ev_addr = a;
        if (v) model_log(syn, a);
    endtask

    task automatic ev_stop();
        @(negedge clk);
        ev_valid = 1'b0; ev_syndrome = '0;
    endtask

    task automatic snap(input bit sel);
        @(negedge clk);
        host_snap = 1'b1; host_sel = sel;
        push_snapshot(sel);
        @(negedge clk);
        host_snap = 1'b0;
    endtask

    task automatic pulse_next();
        @(negedge clk);
        host_next = 1'b1;
        @(negedge clk);
        host_next = 1'b0;
    endtask

    task automatic wait_result(output bit ok);
        ok = 0;
        for (int c = 0; c < 300; c++) begin
            if (flag_valid || scan_done) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_scan(input string tag, input bit hold_test);
        bit ok;
        bit first = 1;
        forever begin
            wait_result(ok);
            if (!ok) begin
                chk(0, {tag, " scan timeout"}, 0, 1);
                break;
            end
            if (flag_valid) begin
                int e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                chk(int'(flag_index) == e, {tag, " flag index"}, int'(flag_index), e);
                if (hold_test && first) begin
                    repeat (3) @(negedge clk);
                    chk(flag_valid && int'(flag_index) == e, "R7 flag held", int'(flag_index), e);
                end
                first = 0;
                pulse_next();
            end else begin
                chk(exp_q.size() == 0, {tag, " done with flags left"}, exp_q.size(), 0);
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(flag_valid == 0, "R1 flag_valid", flag_valid, 0);
        chk(scan_done == 0, "R1 scan_done", scan_done, 0);
        snap(1'b0);
        run_scan("R1", 0);
        snap(1'b1);
        run_scan("R1", 0);

        // R2 R3 R4: logging
        send_ev(1, 5'd3,  18'h05000);
        send_ev(1, 5'd31, 18'h1F000);
        send_ev(1, 5'd1,  18'h00000);
        send_ev(1, 5'd7,  18'h23000);
        send_ev(1, 5'd0,  18'h01000);
        send_ev(0, 5'd9,  18'h02000);
        send_ev(1, 5'd3,  18'h05ABC);
        ev_stop();
        snap(1'b0);
        run_scan("R2", 1);
        // R8: next ignored when done
        pulse_next();
        chk(scan_done == 1 && flag_valid == 0, "R8 next in done", scan_done, 1);
        // R5: other half untouched, then cleared
        snap(1'b1);
        run_scan("R5", 0);
        snap(1'b0);
        run_scan("R5", 0);

        // R6: event on snapshot edge
        send_ev(1, 5'd2, 18'h0A000);
        ev_stop();
        @(negedge clk);
        host_snap = 1'b1; host_sel = 1'b0;
        ev_valid = 1'b1; ev_syndrome = 5'd4; ev_addr = 18'h07000;
        push_snapshot(1'b0);
        model_log(5'd4, 18'h07000);
        @(negedge clk);
        host_snap = 1'b0; ev_valid = 1'b0; ev_syndrome = '0;
        run_scan("R6", 0);
        snap(1'b0);
        run_scan("R6", 0);

        // R10: back-to-back events during a scan, chunk edges
        send_ev(1, 5'd0, 18'h00000);
        send_ev(1, 5'd1, 18'h0F000);
        send_ev(1, 5'd5, 18'h10000);
        ev_stop();
        snap(1'b0);
        fork
            run_scan("R10", 0);
            begin
                for (int k = 0; k < 40; k++)
                    send_ev(1, 5'(k % 31 + 1), {1'b1, 5'(k * 7), 12'h000});
                send_ev(1, 5'd31, 18'h3F000);
                send_ev(1, 5'd1, 18'h20000);
                send_ev(1, 5'd1, 18'h21000);
                ev_stop();
            end
        join
        snap(1'b1);
        run_scan("R10", 0);

        // R9: restart during report
        send_ev(1, 5'd6, 18'h01000);
        send_ev(1, 5'd8, 18'h02000);
        send_ev(1, 5'd9, 18'h24000);
        send_ev(1, 5'd10, 18'h25000);
        ev_stop();
        snap(1'b0);
        begin
            bit ok;
            wait_result(ok);
            chk(ok && flag_valid && int'(flag_index) == 6 * 32 + 1, "R9 first flag",
                int'(flag_index), 6 * 32 + 1);
        end
        snap(1'b1);
        run_scan("R9", 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule